// File: doc/BRIEF.md
# Channel-multiplexed HDLC frame receiver

This block receives bit-stuffed HDLC frames for up to `NCH` logical channels that share a single time-division serial input. Each channel keeps its own receive context in a small on-chip memory. The context holds the ones run, a six-bit delay line of unstuffed bits, the byte assembler, three held bytes, the FCS accumulator and the frame phase. In each enabled cycle the context of the channel chosen on the previous clock reads one line bit. The block writes the updated context back, so any order of channel visits is handled by one datapath.

The caller drives `rx_chan` with the channel whose bit it will present on the next cycle. In that next cycle it drives the bit and `rx_en`. The data byte strobe, frame-end and frame-error outputs describe that same cycle and that same channel. A frame ends with a strobe that carries its final data byte, together with the end flag and the FCS verdict. The two FCS bytes are consumed and never delivered. Either continuous ones or repeated flags may fill the gaps between frames.

Top module: `hdlc_tdm_rx`

## Requirements
- R1: A value on `rx_chan` is captured at a rising edge. `rx_bit`, `rx_en` and every output in the following cycle belong to that channel, and `out_chan` reports it.
- R2: Inside a frame, a 0 that follows five consecutive 1s on the line is discarded. It reaches neither the delivered bytes nor the FCS.
- R3: Bytes are assembled with the first received bit in bit 0. Every data byte is delivered through one `out_valid` cycle. The final data byte of a frame carries `out_end` in that same cycle, and the two trailing FCS bytes are never delivered.
- R4: The FCS is the reflected CRC-16 (polynomial 0x8408, preset 0xFFFF) over data and FCS bits. The frame is good when the remainder equals 0xF0B8. Otherwise `out_err` is raised in the `out_end` cycle, and `out_err` is never raised in any other cycle.
- R5: All-ones fill and back-to-back flags (01111110) between frames produce no output.
- R6: While `rx_en` is low, no output strobes and the channel context is left unchanged, whatever `rx_bit` carries.
- R7: Each channel's context is independent. Frames on different channels may be interleaved bit by bit, or suspended and resumed, without affecting each other.
- R8: Seven or more consecutive 1s abort the frame in progress. No frame end is reported for it, and the channel waits for the next flag.
- R9: A frame with fewer than three bytes, or whose length is not a whole number of bytes, ends with `out_valid`, `out_end` and `out_err` together. For a frame under three bytes, `out_data` is 0x00.
- R10: After reset, every channel is hunting. No output strobes until a flag has opened a frame on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Processes this cycle's bit when high; stalls when low |
| rx_chan | input | CHW | Channel to be served in the next cycle |
| rx_bit | input | 1 | Line bit for the channel captured at the last edge |
| out_valid | output | 1 | Data byte strobe |
| out_end | output | 1 | Final byte of a frame |
| out_err | output | 1 | Frame failed FCS, length or alignment check |
| out_data | output | 8 | Delivered byte, zero when no strobe |
| out_chan | output | CHW | Channel the outputs belong to |

## Verification
The bench builds the receiver with the default of 32 channels, so the channel index is five bits wide and the top channel 31 is reachable. Frames on channels 0, 5, 7, 12 and 31 run through the single-channel path, where each write is read straight back through the bypass register. Interleaved and suspended frames on other channels send the context through the memory read path instead. Payloads of 0xFF and 0x7E force stuffed zeros, and a flipped FCS bit, a two-byte frame, trailing odd bits, an abort and mid-frame stalls cover the error and hold paths.

// File: rtl/hdlc_tdm_rx_pkg.sv
package hdlc_tdm_rx_pkg;

  localparam int BYTE_W = 8;
  // unstuffed bits held back so a closing flag never reaches the assembler
  localparam int DLY_W  = 6;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD   = 16'hF0B8;

  typedef struct packed {
    logic              in_frame;
    logic [2:0]        ones;
    logic [DLY_W-1:0]  dly;
    logic [2:0]        dcnt;
    logic [2:0]        nbit;
    logic [BYTE_W-1:0] acc;
    logic [1:0]        nheld;
    logic [BYTE_W-1:0] h0;
    logic [BYTE_W-1:0] h1;
    logic [BYTE_W-1:0] h2;
    logic [15:0]       crc;
  } rx_ctx_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic [15:0] r;
    r = {1'b0, c[15:1]};
    if (c[0] ^ b) r = r ^ CRC_POLY_R;
    return r;
  endfunction

endpackage

// File: rtl/hdlc_ctx_ram.sv
module hdlc_ctx_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // read-first simple dual port, maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/hdlc_rx_bitproc.sv
module hdlc_rx_bitproc
  import hdlc_tdm_rx_pkg::*;
(
  input  rx_ctx_t            cur,
  input  logic               bit_i,
  output rx_ctx_t            nxt,
  output logic               emit,
  output logic               emit_end,
  output logic               emit_err,
  output logic [BYTE_W-1:0]  emit_data
);

  logic              push;
  logic              pbit;
  logic              flag;
  logic              xit;
  logic              xbit;
  logic [BYTE_W-1:0] newb;

  always_comb begin
    nxt       = cur;
    push      = 1'b0;
    pbit      = 1'b0;
    flag      = 1'b0;
    xit       = 1'b0;
    xbit      = cur.dly[DLY_W-1];
    newb      = {xbit, cur.acc[BYTE_W-1:1]};
    emit      = 1'b0;
    emit_end  = 1'b0;
    emit_err  = 1'b0;
    emit_data = '0;

    // line decode: ones run, stuffing, flag, abort
    if (bit_i) begin
      if (cur.ones != 3'd7) nxt.ones = cur.ones + 3'd1;
      if (cur.ones < 3'd5) begin
        push = cur.in_frame;
        pbit = 1'b1;
      end else if (cur.ones >= 3'd6) begin
        nxt.in_frame = 1'b0;
      end
    end else begin
      nxt.ones = 3'd0;
      if (cur.ones == 3'd6) begin
        flag = 1'b1;
      end else if (cur.ones < 3'd5) begin
        push = cur.in_frame;
      end
    end

    // delay line: a bit leaves only when six newer unstuffed bits follow it
    if (push) begin
      nxt.dly = {cur.dly[DLY_W-2:0], pbit};
      if (cur.dcnt == 3'(DLY_W)) xit = 1'b1;
      else nxt.dcnt = cur.dcnt + 3'd1;
    end

    // byte assembly, FCS and three-byte holdback
    if (xit) begin
      nxt.crc  = crc_step(cur.crc, xbit);
      nxt.acc  = newb;
      nxt.nbit = cur.nbit + 3'd1;
      if (cur.nbit == 3'd7) begin
        if (cur.nheld == 2'd3) begin
          emit      = 1'b1;
          emit_data = cur.h0;
          nxt.h0    = cur.h1;
          nxt.h1    = cur.h2;
          nxt.h2    = newb;
        end else begin
          case (cur.nheld)
            2'd0:    nxt.h0 = newb;
            2'd1:    nxt.h1 = newb;
            default: nxt.h2 = newb;
          endcase
          nxt.nheld = cur.nheld + 2'd1;
        end
      end
    end

    if (flag) begin
      if (cur.in_frame && (cur.nheld != 2'd0 || cur.nbit != 3'd0)) begin
        emit      = 1'b1;
        emit_end  = 1'b1;
        emit_err  = (cur.nheld != 2'd3) || (cur.nbit != 3'd0) || (cur.crc != CRC_GOOD);
        emit_data = (cur.nheld == 2'd3) ? cur.h0 : '0;
      end
      nxt.in_frame = 1'b1;
      nxt.dly      = '0;
      nxt.dcnt     = 3'd0;
      nxt.nbit     = 3'd0;
      nxt.acc      = '0;
      nxt.nheld    = 2'd0;
      nxt.crc      = CRC_PRESET;
    end
  end

endmodule

// File: rtl/hdlc_tdm_rx.sv
module hdlc_tdm_rx
  import hdlc_tdm_rx_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic [CHW-1:0]    rx_chan,
  input  logic              rx_bit,
  output logic              out_valid,
  output logic              out_end,
  output logic              out_err,
  output logic [BYTE_W-1:0] out_data,
  output logic [CHW-1:0]    out_chan
);

  localparam int CTX_W = $bits(rx_ctx_t);

  logic [CHW-1:0]   sel_q;
  logic             sel_v;
  logic [NCH-1:0]   seen_q;
  logic             byp_q;
  rx_ctx_t          byp_d_q;
  logic [CTX_W-1:0] ram_rd;
  rx_ctx_t          cur;
  rx_ctx_t          nxt;
  logic             we;
  logic             emit;
  logic             emit_end;
  logic             emit_err;
  logic [BYTE_W-1:0] emit_data;

  assign we = sel_v & rx_en & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      sel_v   <= 1'b0;
      seen_q  <= '0;
      byp_q   <= 1'b0;
      byp_d_q <= '0;
    end else begin
      sel_q   <= rx_chan;
      sel_v   <= 1'b1;
      byp_q   <= we && (sel_q == rx_chan);
      byp_d_q <= nxt;
      if (we) seen_q[sel_q] <= 1'b1;
    end
  end

  hdlc_ctx_ram #(
    .DEPTH (NCH),
    .WIDTH (CTX_W)
  ) ctx_ram_i (
    .clk   (clk),
    .we    (we),
    .waddr (sel_q),
    .wdata (nxt),
    .raddr (rx_chan),
    .rdata (ram_rd)
  );

  // a never-written channel reads as a cleared, hunting context
  always_comb begin
    if (!seen_q[sel_q])  cur = '0;
    else if (byp_q)      cur = byp_d_q;
    else                 cur = rx_ctx_t'(ram_rd);
  end

  hdlc_rx_bitproc bitproc_i (
    .cur       (cur),
    .bit_i     (rx_bit),
    .nxt       (nxt),
    .emit      (emit),
    .emit_end  (emit_end),
    .emit_err  (emit_err),
    .emit_data (emit_data)
  );

  assign out_valid = we & emit;
  assign out_end   = we & emit_end;
  assign out_err   = we & emit_err;
  assign out_data  = out_valid ? emit_data : '0;
  assign out_chan  = sel_q;

endmodule

// File: rtl/hdlc_tdm_rx_chk.sv
module hdlc_tdm_rx_chk #(
  parameter int CHW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           rx_en,
  input logic [CHW-1:0] rx_chan,
  input logic           out_valid,
  input logic           out_end,
  input logic           out_err,
  input logic [CHW-1:0] out_chan
);

  AST_CHAN_FOLLOWS_SELECT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_chan == $past(rx_chan))); // R1

  AST_END_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    out_end |-> out_valid); // R3

  AST_ERR_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_end); // R4

  AST_NO_END_PAIR_SAME_CHAN: assert property (@(posedge clk) disable iff (rst)
    (out_end && $past(out_end)) |-> (out_chan != $past(out_chan))); // R5

  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
    !rx_en |-> !out_valid); // R6

endmodule

bind hdlc_tdm_rx hdlc_tdm_rx_chk #(.CHW(CHW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .rx_en     (rx_en),
  .rx_chan   (rx_chan),
  .out_valid (out_valid),
  .out_end   (out_end),
  .out_err   (out_err),
  .out_chan  (out_chan)
);

// File: tb/hdlc_tdm_rx_tb_top.sv
module hdlc_tdm_rx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int CHW = 5;
  localparam int NTBL = 6;
  // entry: {chan[4:0], data byte count[2:0], corrupt FCS, bytes with first in [7:0]}
  localparam logic [40:0] TBL [NTBL] = '{
    {5'd0,  3'd1, 1'b0, 32'h0000_00C3},
    {5'd5,  3'd3, 1'b0, 32'h007E_FF01},
    {5'd31, 3'd4, 1'b0, 32'hFC1F_F83F},
    {5'd7,  3'd2, 1'b1, 32'h0000_55AA},
    {5'd12, 3'd4, 1'b0, 32'hFFFF_FFFF},
    {5'd31, 3'd1, 1'b1, 32'h0000_0000}
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           rx_en = 1'b0;
  logic [CHW-1:0] rx_chan = '0;
  logic           rx_bit = 1'b1;
  logic           out_valid, out_end, out_err;
  logic [7:0]     out_data;
  logic [CHW-1:0] out_chan;

  int total = 0;
  int bad = 0;
  logic [7:0]     cap_d [$];
  logic           cap_e [$];
  logic           cap_r [$];
  logic [CHW-1:0] cap_c [$];
  bit qa [$];
  bit qb [$];
  int ra = 0;
  int rb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_tdm_rx #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_chan(rx_chan), .rx_bit(rx_bit),
    .out_valid(out_valid), .out_end(out_end), .out_err(out_err),
    .out_data(out_data), .out_chan(out_chan)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(logic [CHW-1:0] nsel, logic b, logic en);
    @(negedge clk);
    rx_chan = nsel; rx_bit = b; rx_en = en;
    #(CLK_PERIOD/4);
    if (out_valid) begin
      cap_d.push_back(out_data); cap_e.push_back(out_end);
      cap_r.push_back(out_err);  cap_c.push_back(out_chan);
    end
  endtask

  task automatic clear_cap();
    cap_d.delete(); cap_e.delete(); cap_r.delete(); cap_c.delete();
  endtask

  task automatic put_raw(ref bit q[$], ref int run, input logic b);
    q.push_back(b);
    if (b) begin
      run++;
      if (run == 5) begin q.push_back(1'b0); run = 0; end
    end else run = 0;
  endtask

  task automatic put_byte(ref bit q[$], ref int run, input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_raw(q, run, v[i]);
  endtask

  task automatic put_flag(ref bit q[$], ref int run);
    q.push_back(1'b0);
    for (int i = 0; i < 6; i++) q.push_back(1'b1);
    q.push_back(1'b0);
    run = 0;
  endtask

  task automatic put_ones(ref bit q[$], ref int run, input int n);
    for (int i = 0; i < n; i++) q.push_back(1'b1);
    run = 0;
  endtask

  function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] v);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ v[i];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  // data bytes, FCS (low byte first, optionally corrupted), closing flag
  task automatic put_frame(ref bit q[$], ref int run, input int n, input logic [31:0] d, input bit bad_fcs);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] f;
    for (int i = 0; i < n; i++) begin
      put_byte(q, run, d[8*i +: 8]);
      c = crc_byte(c, d[8*i +: 8]);
    end
    f = ~c;
    if (bad_fcs) f = f ^ 16'h0001;
    put_byte(q, run, f[7:0]);
    put_byte(q, run, f[15:8]);
    put_flag(q, run);
  endtask

  task automatic run_line(logic [CHW-1:0] ch, ref bit q[$]);
    step(ch, 1'b1, 1'b0);
    foreach (q[i]) step(ch, q[i], 1'b1);
    step(ch, 1'b1, 1'b0);
    q.delete();
  endtask

  task automatic expect_ch(string req, logic [CHW-1:0] ch, int n, logic [31:0] d, bit e, logic zero_data);
    int k = 0;
    for (int i = 0; i < cap_d.size(); i++) begin
      if (cap_c[i] == ch) begin
        if (k < n) begin
          chk(req, "data", cap_d[i], zero_data ? 8'h00 : d[8*k +: 8]);
          chk(req, "end",  cap_e[i], (k == n-1));
          chk("R4", "err", cap_r[i], e && (k == n-1));
        end
        k++;
      end
    end
    chk(req, "strobe count", k, n);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R10: quiet during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #(CLK_PERIOD/4);
      chk("R10", "valid in reset", out_valid, 1'b0);
    end
    @(negedge clk); rst = 1'b0;

    // R10: hunting channel ignores data with no flag; R5: ones and repeated flags
    put_ones(qa, ra, 30);
    put_byte(qa, ra, 8'h00); put_byte(qa, ra, 8'h5A); put_byte(qa, ra, 8'h3C);
    run_line(5'd1, qa);
    chk("R10", "strobes before flag", cap_d.size(), 0);
    put_flag(qa, ra); put_flag(qa, ra); put_flag(qa, ra);
    put_ones(qa, ra, 20);
    put_flag(qa, ra); put_flag(qa, ra);
    run_line(5'd1, qa);
    chk("R5", "strobes on fill", cap_d.size(), 0);
    clear_cap();

    // table walk: R3 good frames, R2 stuffing payloads, R4 corrupted FCS
    for (int t = 0; t < NTBL; t++) begin
      logic [CHW-1:0] ch = TBL[t][40:36];
      int n = int'(TBL[t][35:33]);
      put_flag(qa, ra); put_flag(qa, ra);
      put_frame(qa, ra, n, TBL[t][31:0], TBL[t][32]);
      put_ones(qa, ra, 10);
      run_line(ch, qa);
      expect_ch((TBL[t][31:0] == 32'hFFFF_FFFF || t == 1) ? "R2" : "R3",
                ch, n, TBL[t][31:0], TBL[t][32], 1'b0);
      chk("R1", "total strobes", cap_d.size(), n);
      clear_cap();
    end

    // R7: two channels interleaved bit by bit through the shared datapath
    put_flag(qa, ra); put_frame(qa, ra, 3, 32'h0033_2211, 1'b0);
    put_flag(qb, rb); put_frame(qb, rb, 2, 32'h0000_BBAA, 1'b1);
    while (qb.size() < qa.size()) qb.push_back(1'b1);
    while (qa.size() < qb.size()) qa.push_back(1'b1);
    step(5'd3, 1'b1, 1'b0);
    for (int i = 0; i < qa.size(); i++) begin
      step(5'd4, qa[i], 1'b1);
      step(5'd3, qb[i], 1'b1);
    end
    qa.delete(); qb.delete();
    expect_ch("R7", 5'd3, 3, 32'h0033_2211, 1'b0, 1'b0);
    expect_ch("R7", 5'd4, 2, 32'h0000_BBAA, 1'b1, 1'b0);
    clear_cap();

    // R7: suspend channel 10 mid-frame, run channel 11, resume channel 10
    put_flag(qa, ra); put_byte(qa, ra, 8'h9C); put_byte(qa, ra, 8'h01);
    run_line(5'd10, qa);
    put_flag(qb, rb); put_frame(qb, rb, 1, 32'h0000_00E7, 1'b0);
    run_line(5'd11, qb);
    begin
      logic [15:0] c = crc_byte(crc_byte(crc_byte(16'hFFFF, 8'h9C), 8'h01), 8'h42);
      put_byte(qa, ra, 8'h42);
      put_byte(qa, ra, ~c[7:0]); put_byte(qa, ra, ~c[15:8]);
      put_flag(qa, ra);
    end
    run_line(5'd10, qa);
    expect_ch("R7", 5'd11, 1, 32'h0000_00E7, 1'b0, 1'b0);
    expect_ch("R7", 5'd10, 3, 32'h0042_019C, 1'b0, 1'b0);
    clear_cap();

    // R6: stalled cycles carrying garbage zeros leave the frame intact
    put_flag(qa, ra); put_frame(qa, ra, 3, 32'h0080_7F10, 1'b0);
    step(5'd9, 1'b1, 1'b0);
    for (int i = 0; i < qa.size(); i++) begin
      if (i % 3 == 1) begin
        step(5'd9, 1'b0, 1'b0);
        step(5'd9, 1'b0, 1'b0);
      end
      step(5'd9, qa[i], 1'b1);
    end
    qa.delete();
    step(5'd9, 1'b1, 1'b0);
    expect_ch("R6", 5'd9, 3, 32'h0080_7F10, 1'b0, 1'b0);
    clear_cap();

    // R8: abort after two bytes gives no end; later frame still decodes
    put_flag(qa, ra); put_byte(qa, ra, 8'h12); put_byte(qa, ra, 8'h34);
    put_ones(qa, ra, 17);
    run_line(5'd2, qa);
    chk("R8", "strobes after abort", cap_d.size(), 0);
    put_flag(qa, ra); put_frame(qa, ra, 1, 32'h0000_0077, 1'b0);
    run_line(5'd2, qa);
    expect_ch("R8", 5'd2, 1, 32'h0000_0077, 1'b0, 1'b0);
    clear_cap();

    // R9: two-byte frame is flagged with zero data
    put_flag(qa, ra); put_byte(qa, ra, 8'hA5); put_byte(qa, ra, 8'h0F); put_flag(qa, ra);
    run_line(5'd6, qa);
    expect_ch("R9", 5'd6, 1, 32'h0, 1'b1, 1'b1);
    clear_cap();

    // R9: good frame followed by three stray bits is flagged
    put_flag(qa, ra); put_byte(qa, ra, 8'h42);
    begin
      logic [15:0] c = ~crc_byte(16'hFFFF, 8'h42);
      put_byte(qa, ra, c[7:0]); put_byte(qa, ra, c[15:8]);
    end
    put_raw(qa, ra, 1'b0); put_raw(qa, ra, 1'b1); put_raw(qa, ra, 1'b0);
    put_flag(qa, ra);
    run_line(5'd6, qa);
    expect_ch("R9", 5'd6, 1, 32'h0000_0042, 1'b1, 1'b0);
    clear_cap();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule